// File: doc/BRIEF.md
# Serial Port Control and Status Register Front End

This block is the register-level front end of a byte-oriented serial port. A processor reaches it through single-cycle byte reads and writes. Registers sit at word-spaced offsets, and the offset is the low six bits of the bus address, so any address above the 64-byte window aliases back into it.

Behind the window the block holds:
- two mode bytes, reached through a one-bit pointer that moves to the second byte after any mode write;
- an interrupt mask;
- a delta-break flag;
- a one-byte transmit holding register;
- the enable states of the transmitter and receiver.

A single command byte carries three independent subcommands. They apply in a fixed order: a miscellaneous action first, then a transmitter action, then a receiver action. The receive FIFO lives outside the block. It reports its ready and full flags and its head byte, and the block returns pop, flush and enable strobes to it. Transmit bytes leave through a valid/ready handshake. One level interrupt is high whenever an enabled interrupt source is active.

The transmit path is a four-state machine:

| State | Meaning |
|---|---|
| `TX_OFF` | disabled, holding register empty |
| `TX_IDLE` | enabled, empty |
| `TX_PEND` | enabled, byte waiting; `tx_valid_o` high |
| `TX_HELD` | disabled, byte waiting |

Its transitions:

| Transition | Path | Cause |
|---|---|---|
| *handoff* | `TX_PEND`→`TX_IDLE` | valid and ready both high |
| *load* | `TX_IDLE`/`TX_PEND`→`TX_PEND` | transmit write while enabled |
| *load* | `TX_OFF`/`TX_HELD`→`TX_HELD` | transmit write while disabled |
| *reset* | any→`TX_OFF` | command 3 |
| *enable* | `TX_OFF`→`TX_IDLE` | transmitter enable subcommand |
| *enable* | `TX_HELD`→`TX_PEND` | transmitter enable subcommand |
| *disable* | `TX_IDLE`→`TX_OFF` | transmitter disable subcommand |
| *disable* | `TX_PEND`→`TX_HELD` | transmitter disable subcommand |

Within one cycle these apply in the order handoff, load, reset, enable, disable.

Top module: `sercon_regs`

## Requirements
- R1: After reset the status reads 0x08, the interrupt status, both mode bytes and the mask read 0, and `irq_o`, `tx_valid_o` and `rx_en_o` are low.
- R2: Offset 0x00 reads and writes the mode byte picked by the pointer. Any write there moves the pointer to byte 1. The miscellaneous code 1 (command bits [6:4]) returns it to byte 0. Only address bits [5:0] select the offset.
- R3: Status bits: [0] = `rx_rdy_i`, [1] = `rx_full_i`, [2] = transmitter enabled, [3] = holding register empty, [7:4] = 0.
- R4: Command bits [3:2] act on the transmitter and bits [1:0] on the receiver (`rx_en_o`). In both fields, 1 enables, 2 disables, and 0 or 3 leaves the state unchanged. The receiver and transmitter fields act after the miscellaneous field of the same byte.
- R5: Miscellaneous code 2 disables the receiver and pulses `rx_flush_o` high for the following cycle. Code 3 disables the transmitter and empties the holding register, discarding a waiting byte.
- R6: A write at 0x0C stores the byte and clears empty. `tx_valid_o` is high exactly when the transmitter is enabled and not empty, with `tx_data_o` the stored byte. A cycle with valid and ready both high sends the byte and sets empty.
- R7: A transmit write in the same cycle as a handoff leaves the new byte waiting, and empty stays clear.
- R8: Interrupt status bit 0 is transmitter-ready. Bit 1 is `rx_full_i` when mode byte 0 bit 6 is set, otherwise `rx_rdy_i`. Bit 2 is set by `brk_evt_i` and cleared by miscellaneous code 5; a set in the same cycle wins. Bits 7:3 read 0.
- R9: A write at 0x14 loads the mask. `irq_o` is high exactly when interrupt status AND mask is nonzero.
- R10: Writes at 0x04, 0x10 and unlisted offsets change nothing. Reads at 0x10 and unlisted offsets return 0.
- R11: A read at 0x0C returns `rx_data_i` and raises `rx_pop_o` when `rx_rdy_i` is high. Otherwise it returns 0 with no pop.
- R12: Offsets 0x18 and 0x1C read the parameters `BAUD_HI` and `BAUD_LO`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset, synchronous |
| bus_addr | input | ADDR_W | byte address; bits [5:0] select the register |
| bus_wr | input | 1 | write strobe |
| bus_rd | input | 1 | read strobe |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data, combinational from address |
| rx_rdy_i | input | 1 | FIFO holds at least one byte |
| rx_full_i | input | 1 | FIFO is full |
| rx_data_i | input | 8 | FIFO head byte |
| rx_pop_o | output | 1 | remove head byte this cycle |
| rx_flush_o | output | 1 | one-cycle FIFO flush |
| rx_en_o | output | 1 | receiver enabled |
| brk_evt_i | input | 1 | break seen on the line (one-cycle pulse) |
| tx_valid_o | output | 1 | a byte is offered to the serializer |
| tx_ready_i | input | 1 | serializer accepts the byte |
| tx_data_o | output | 8 | offered byte |
| irq_o | output | 1 | level interrupt |

## Verification
Two transmit events can fall in the same cycle: the serializer accepting the waiting byte, and the processor writing the next one. The bench provokes this by raising `tx_ready_i` in the cycle that carries the second transmit write. It then requires `tx_valid_o` to stay high with the new byte and the status to show not-empty, and expects the byte to leave only one cycle later. A second collision is a break event arriving together with the command that clears the break flag. There the bench expects interrupt status bit 2 to remain set.

// File: rtl/sercon_pkg.sv
package sercon_pkg;

    localparam int BYTE_W = 8;
    localparam int OFS_W  = 6;

    localparam logic [OFS_W-1:0] OFS_MODE  = 6'h00;
    localparam logic [OFS_W-1:0] OFS_STAT  = 6'h04;
    localparam logic [OFS_W-1:0] OFS_CMD   = 6'h08;
    localparam logic [OFS_W-1:0] OFS_DATA  = 6'h0C;
    localparam logic [OFS_W-1:0] OFS_AUX   = 6'h10;
    localparam logic [OFS_W-1:0] OFS_INT   = 6'h14;
    localparam logic [OFS_W-1:0] OFS_BAUD1 = 6'h18;
    localparam logic [OFS_W-1:0] OFS_BAUD2 = 6'h1C;

    // status bit positions
    localparam int ST_RXRDY = 0;
    localparam int ST_FULL  = 1;
    localparam int ST_TXRDY = 2;
    localparam int ST_TXEMP = 3;

    // interrupt status bit positions
    localparam int IS_TX  = 0;
    localparam int IS_RX  = 1;
    localparam int IS_BRK = 2;
    localparam int IS_COS = 7;

    // mode byte 0 bit that steers receive interrupt to the full flag
    localparam int MODE_FULL_SEL = 6;

    typedef enum logic [2:0] {
        MISC_NOP     = 3'd0,
        MISC_PTR_CLR = 3'd1,
        MISC_RX_RST  = 3'd2,
        MISC_TX_RST  = 3'd3,
        MISC_ERR_RST = 3'd4,
        MISC_BRK_CLR = 3'd5,
        MISC_BRK_ON  = 3'd6,
        MISC_BRK_OFF = 3'd7
    } misc_e;

    typedef enum logic [1:0] {
        PATH_KEEP = 2'd0,
        PATH_ON   = 2'd1,
        PATH_OFF  = 2'd2,
        PATH_RSVD = 2'd3
    } path_e;

    typedef struct packed {
        logic ptr_clr;
        logic rx_rst;
        logic tx_rst;
        logic brk_clr;
        logic tx_on;
        logic tx_off;
        logic rx_on;
        logic rx_off;
    } cmd_act_t;

    typedef enum logic [1:0] {
        TX_OFF  = 2'd0,
        TX_IDLE = 2'd1,
        TX_PEND = 2'd2,
        TX_HELD = 2'd3
    } tx_state_e;

endpackage

// File: rtl/sercon_cmd_dec.sv
module sercon_cmd_dec
    import sercon_pkg::*;
(
    input  logic              cmd_wr_i,
    input  logic [BYTE_W-1:0] cmd_i,
    output cmd_act_t          act_o
);

    misc_e misc;
    path_e tx_fld;
    path_e rx_fld;

    always_comb begin
        misc   = misc_e'(cmd_i[6:4]);
        tx_fld = path_e'(cmd_i[3:2]);
        rx_fld = path_e'(cmd_i[1:0]);
    end

    always_comb begin
        act_o = '0;
        if (cmd_wr_i) begin
            unique case (misc)
                MISC_NOP:     ;
                MISC_PTR_CLR: act_o.ptr_clr = 1'b1;
                MISC_RX_RST:  act_o.rx_rst  = 1'b1;
                MISC_TX_RST:  act_o.tx_rst  = 1'b1;
                MISC_ERR_RST: ;
                MISC_BRK_CLR: act_o.brk_clr = 1'b1;
                MISC_BRK_ON:  ;
                MISC_BRK_OFF: ;
            endcase
            unique case (tx_fld)
                PATH_KEEP: ;
                PATH_ON:   act_o.tx_on  = 1'b1;
                PATH_OFF:  act_o.tx_off = 1'b1;
                PATH_RSVD: ;
            endcase
            unique case (rx_fld)
                PATH_KEEP: ;
                PATH_ON:   act_o.rx_on  = 1'b1;
                PATH_OFF:  act_o.rx_off = 1'b1;
                PATH_RSVD: ;
            endcase
        end
    end

endmodule

// File: rtl/sercon_tx_fsm.sv
module sercon_tx_fsm
    import sercon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  cmd_act_t          act_i,
    input  logic              tx_ready_i,
    output logic              tx_valid_o,
    output logic [BYTE_W-1:0] tx_data_o,
    output logic              tx_rdy_o,
    output logic              tx_empty_o
);

    tx_state_e state_q, state_d, s_hand, s_load, s_rst, s_on;
    logic [BYTE_W-1:0] hold_q;

    // next-state: handoff, load, reset, enable, disable in that order
    always_comb begin
        s_hand = state_q;
        if (state_q == TX_PEND && tx_ready_i)
            s_hand = TX_IDLE;

        s_load = s_hand;
        if (load_i) begin
            unique case (s_hand)
                TX_OFF, TX_HELD:  s_load = TX_HELD;
                TX_IDLE, TX_PEND: s_load = TX_PEND;
            endcase
        end

        s_rst = act_i.tx_rst ? TX_OFF : s_load;

        s_on = s_rst;
        if (act_i.tx_on) begin
            unique case (s_rst)
                TX_OFF:  s_on = TX_IDLE;
                TX_HELD: s_on = TX_PEND;
                TX_IDLE, TX_PEND: ;
            endcase
        end

        state_d = s_on;
        if (act_i.tx_off) begin
            unique case (s_on)
                TX_IDLE: state_d = TX_OFF;
                TX_PEND: state_d = TX_HELD;
                TX_OFF, TX_HELD: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_OFF;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (load_i)
                hold_q <= wdata_i;
        end
    end

    always_comb begin
        tx_valid_o = 1'b0;
        tx_rdy_o   = 1'b0;
        tx_empty_o = 1'b1;
        unique case (state_q)
            TX_OFF:  ;
            TX_IDLE: tx_rdy_o = 1'b1;
            TX_PEND: begin
                tx_rdy_o   = 1'b1;
                tx_empty_o = 1'b0;
                tx_valid_o = 1'b1;
            end
            TX_HELD: tx_empty_o = 1'b0;
        endcase
        tx_data_o = hold_q;
    end

    // R6: a completed handoff without a new byte leaves nothing offered
    a_r6_handoff_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && tx_ready_i && !load_i) |=> !tx_valid_o);

    // R6: an offered byte is held until accepted or withdrawn
    a_r6_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i && !load_i && !act_i.tx_off && !act_i.tx_rst)
        |=> (tx_valid_o && $stable(tx_data_o)));

    // R7: a transmit write always leaves a byte waiting
    a_r7_load_pending: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !tx_empty_o);

endmodule

// File: rtl/sercon_irq.sv
module sercon_irq
    import sercon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_rdy_i,
    input  logic              rx_rdy_i,
    input  logic              rx_full_i,
    input  logic              full_sel_i,
    input  logic              brk_evt_i,
    input  logic              brk_clr_i,
    input  logic              mask_wr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] isr_o,
    output logic              irq_o
);

    logic [BYTE_W-1:0] mask_q;
    logic              dbrk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            dbrk_q <= 1'b0;
        end else begin
            if (mask_wr_i)
                mask_q <= wdata_i;
            if (brk_evt_i)
                dbrk_q <= 1'b1;
            else if (brk_clr_i)
                dbrk_q <= 1'b0;
        end
    end

    always_comb begin
        isr_o         = '0;
        isr_o[IS_TX]  = tx_rdy_i;
        isr_o[IS_RX]  = full_sel_i ? rx_full_i : rx_rdy_i;
        isr_o[IS_BRK] = dbrk_q;
        isr_o[IS_COS] = 1'b0;
        irq_o         = |(isr_o & mask_q);
    end

    // R8: a break event always raises the delta-break bit
    a_r8_brk_set: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt_i |=> isr_o[IS_BRK]);

    // R8: the delta-break bit is sticky until cleared
    a_r8_brk_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_o[IS_BRK] && !brk_clr_i) |=> isr_o[IS_BRK]);

    // R8: a clear without a competing event drops it
    a_r8_brk_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_clr_i && !brk_evt_i) |=> !isr_o[IS_BRK]);

endmodule

// File: rtl/sercon_regs.sv
module sercon_regs
    import sercon_pkg::*;
#(
    parameter int               ADDR_W  = 12,
    parameter logic [BYTE_W-1:0] BAUD_HI = 8'h00,
    parameter logic [BYTE_W-1:0] BAUD_LO = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              rx_rdy_i,
    input  logic              rx_full_i,
    input  logic [7:0]        rx_data_i,
    output logic              rx_pop_o,
    output logic              rx_flush_o,
    output logic              rx_en_o,
    input  logic              brk_evt_i,
    output logic              tx_valid_o,
    input  logic              tx_ready_i,
    output logic [7:0]        tx_data_o,
    output logic              irq_o
);

    localparam int MODE_N = 2;

    logic [OFS_W-1:0]  ofs;
    logic              wr_mode, wr_cmd, wr_data, wr_mask;
    logic              rd_data;
    logic              ptr_q;
    logic [BYTE_W-1:0] mode_q [MODE_N];
    logic              rx_en_q, flush_q;
    cmd_act_t          act;
    logic              tx_rdy, tx_empty;
    logic [BYTE_W-1:0] status, isr;

    always_comb begin
        ofs     = bus_addr[OFS_W-1:0];
        wr_mode = bus_wr && (ofs == OFS_MODE);
        wr_cmd  = bus_wr && (ofs == OFS_CMD);
        wr_data = bus_wr && (ofs == OFS_DATA);
        wr_mask = bus_wr && (ofs == OFS_INT);
        rd_data = bus_rd && (ofs == OFS_DATA);
    end

    sercon_cmd_dec u_dec (
        .cmd_wr_i (wr_cmd),
        .cmd_i    (bus_wdata),
        .act_o    (act)
    );

    // mode bytes selected by the pointer
    for (genvar g = 0; g < MODE_N; g++) begin : g_mode
        always_ff @(posedge clk) begin
            if (!rst_n)
                mode_q[g] <= '0;
            else if (wr_mode && (ptr_q == 1'(g)))
                mode_q[g] <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= 1'b0;
            rx_en_q <= 1'b0;
            flush_q <= 1'b0;
        end else begin
            if (wr_mode)
                ptr_q <= 1'b1;
            else if (act.ptr_clr)
                ptr_q <= 1'b0;

            if (act.rx_on)
                rx_en_q <= 1'b1;
            else if (act.rx_off || act.rx_rst)
                rx_en_q <= 1'b0;

            flush_q <= act.rx_rst;
        end
    end

    sercon_tx_fsm u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (wr_data),
        .wdata_i    (bus_wdata),
        .act_i      (act),
        .tx_ready_i (tx_ready_i),
        .tx_valid_o (tx_valid_o),
        .tx_data_o  (tx_data_o),
        .tx_rdy_o   (tx_rdy),
        .tx_empty_o (tx_empty)
    );

    sercon_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_rdy_i   (tx_rdy),
        .rx_rdy_i   (rx_rdy_i),
        .rx_full_i  (rx_full_i),
        .full_sel_i (mode_q[0][MODE_FULL_SEL]),
        .brk_evt_i  (brk_evt_i),
        .brk_clr_i  (act.brk_clr),
        .mask_wr_i  (wr_mask),
        .wdata_i    (bus_wdata),
        .isr_o      (isr),
        .irq_o      (irq_o)
    );

    always_comb begin
        status           = '0;
        status[ST_RXRDY] = rx_rdy_i;
        status[ST_FULL]  = rx_full_i;
        status[ST_TXRDY] = tx_rdy;
        status[ST_TXEMP] = tx_empty;
    end

    always_comb begin
        unique case (ofs)
            OFS_MODE:  bus_rdata = mode_q[ptr_q];
            OFS_STAT:  bus_rdata = status;
            OFS_DATA:  bus_rdata = rx_rdy_i ? rx_data_i : '0;
            OFS_INT:   bus_rdata = isr;
            OFS_BAUD1: bus_rdata = BAUD_HI;
            OFS_BAUD2: bus_rdata = BAUD_LO;
            default:   bus_rdata = '0;
        endcase
    end

    assign rx_pop_o   = rd_data && rx_rdy_i;
    assign rx_flush_o = flush_q;
    assign rx_en_o    = rx_en_q;

    // R2: the pointer sits on byte 1 after any mode write
    a_r2_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |=> (ptr_q == 1'b1));

    // R4: a receiver disable subcommand drops the enable
    a_r4_rx_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && bus_wdata[1:0] == 2'd2) |=> !rx_en_o);

    // R5: a receiver reset without re-enable flushes and disables
    a_r5_rx_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && bus_wdata[6:4] == 3'd2 && bus_wdata[1:0] != 2'd1)
        |=> (rx_flush_o && !rx_en_o));

    // R11: a pop only happens when the FIFO has data
    a_r11_pop_gated: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop_o |-> (rx_rdy_i && bus_rd));

endmodule

// File: tb/sercon_regs_bench.sv
module sercon_regs_bench;

    localparam logic [7:0] B_HI = 8'hA5;
    localparam logic [7:0] B_LO = 8'h3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        rx_rdy_i = 1'b0, rx_full_i = 1'b0;
    logic [7:0]  rx_data_i = '0;
    logic        rx_pop_o, rx_flush_o, rx_en_o;
    logic        brk_evt_i = 1'b0;
    logic        tx_valid_o, tx_ready_i = 1'b0;
    logic [7:0]  tx_data_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] q_exp [$];
    string      q_tag [$];

    always #10 clk = ~clk;

    sercon_regs #(.ADDR_W(12), .BAUD_HI(B_HI), .BAUD_LO(B_LO)) u_sercon_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_rdy_i(rx_rdy_i), .rx_full_i(rx_full_i), .rx_data_i(rx_data_i),
        .rx_pop_o(rx_pop_o), .rx_flush_o(rx_flush_o), .rx_en_o(rx_en_o),
        .brk_evt_i(brk_evt_i), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
        .tx_data_o(tx_data_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: compares each read result against the scoreboard
    always @(negedge clk) begin
        if (bus_rd && q_exp.size() > 0) begin
            logic [7:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            chk(t, bus_rdata, e);
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [7:0] e, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        q_exp.push_back(e);
        q_tag.push_back(tag);
        tick();
        bus_rd = 1'b0;
    endtask

    // read of the receive offset also judges the pop strobe mid-cycle
    task automatic rd_pop(input logic [7:0] e, input logic pop, input string tag);
        bus_addr = 12'h00C; bus_rd = 1'b1;
        q_exp.push_back(e);
        q_tag.push_back(tag);
        #5 chk({tag, " pop"}, rx_pop_o, pop);
        tick();
        bus_rd = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();

        // R1 reset state
        rd(12'h004, 8'h08, "R1 status");
        rd(12'h014, 8'h00, "R1 isr");
        rd(12'h000, 8'h00, "R1 mode0");
        chk("R1 irq", irq_o, 0);
        chk("R1 tx_valid", tx_valid_o, 0);
        chk("R1 rx_en", rx_en_o, 0);

        // R12 baud bytes
        rd(12'h018, B_HI, "R12 baud hi");
        rd(12'h01C, B_LO, "R12 baud lo");

        // R2 mode pointer
        wr(12'h000, 8'h13);
        wr(12'h000, 8'h27);
        rd(12'h000, 8'h27, "R2 ptr on byte1");
        wr(12'h000, 8'h55);
        rd(12'h000, 8'h55, "R2 byte1 rewritten");
        wr(12'h008, 8'h10);
        rd(12'h000, 8'h13, "R2 ptr cleared");
        rd(12'h140, 8'h13, "R2 alias above window");

        // R10 ignored writes and zero reads
        wr(12'h004, 8'hFF);
        wr(12'h010, 8'hFF);
        wr(12'h024, 8'hFF);
        wr(12'h03C, 8'hFF);
        rd(12'h004, 8'h08, "R10 status untouched");
        rd(12'h010, 8'h00, "R10 aux reads zero");
        rd(12'h020, 8'h00, "R10 unlisted reads zero");
        rd(12'h000, 8'h13, "R10 mode untouched");
        chk("R10 irq", irq_o, 0);

        // R3 status from FIFO flags
        rx_rdy_i = 1'b1;
        rd(12'h004, 8'h09, "R3 rx ready");
        rx_full_i = 1'b1;
        rd(12'h004, 8'h0B, "R3 full");
        rx_rdy_i = 1'b0; rx_full_i = 1'b0;

        // R4/R6 enable and send
        wr(12'h008, 8'h04);
        rd(12'h004, 8'h0C, "R4 tx enabled");
        rd(12'h014, 8'h01, "R8 tx int");
        wr(12'h00C, 8'h5A);
        chk("R6 valid", tx_valid_o, 1);
        chk("R6 data", tx_data_o, 8'h5A);
        rd(12'h004, 8'h04, "R6 not empty");
        tx_ready_i = 1'b1;
        tick();
        tx_ready_i = 1'b0;
        chk("R6 sent valid", tx_valid_o, 0);
        rd(12'h004, 8'h0C, "R6 empty again");

        // R7 write colliding with handoff
        wr(12'h00C, 8'hA1);
        tx_ready_i = 1'b1;
        wr(12'h00C, 8'hB2);
        tx_ready_i = 1'b0;
        chk("R7 valid", tx_valid_o, 1);
        chk("R7 data", tx_data_o, 8'hB2);
        rd(12'h004, 8'h04, "R7 not empty");
        tx_ready_i = 1'b1;
        tick();
        tx_ready_i = 1'b0;
        rd(12'h004, 8'h0C, "R7 second sent");

        // R4 disable, reserved code, held byte
        wr(12'h008, 8'h08);
        rd(12'h004, 8'h08, "R4 tx disabled");
        wr(12'h008, 8'h0C);
        rd(12'h004, 8'h08, "R4 tx reserved");
        wr(12'h00C, 8'h77);
        chk("R6 held no valid", tx_valid_o, 0);
        rd(12'h004, 8'h00, "R6 held status");
        wr(12'h008, 8'h04);
        chk("R4 re-enable valid", tx_valid_o, 1);
        chk("R4 re-enable data", tx_data_o, 8'h77);

        // R5 transmitter reset, then reset+enable in one byte
        wr(12'h008, 8'h30);
        chk("R5 tx reset valid", tx_valid_o, 0);
        rd(12'h004, 8'h08, "R5 tx reset status");
        wr(12'h008, 8'h34);
        rd(12'h004, 8'h0C, "R4 order misc then tx");

        // R4/R5 receiver
        wr(12'h008, 8'h01);
        chk("R4 rx on", rx_en_o, 1);
        wr(12'h008, 8'h03);
        chk("R4 rx reserved", rx_en_o, 1);
        wr(12'h008, 8'h02);
        chk("R4 rx off", rx_en_o, 0);
        wr(12'h008, 8'h01);
        wr(12'h008, 8'h20);
        chk("R5 rx reset en", rx_en_o, 0);
        chk("R5 flush pulse", rx_flush_o, 1);
        tick();
        chk("R5 flush ends", rx_flush_o, 0);
        wr(12'h008, 8'h21);
        chk("R4 rx reset then on", rx_en_o, 1);
        chk("R5 flush with on", rx_flush_o, 1);

        // R11 receive read
        rx_rdy_i = 1'b1; rx_data_i = 8'hC3;
        rd_pop(8'hC3, 1'b1, "R11 data");
        rx_rdy_i = 1'b0;
        rd_pop(8'h00, 1'b0, "R11 empty");

        // R8/R9 interrupts (tx enabled)
        wr(12'h014, 8'h01);
        chk("R9 tx irq", irq_o, 1);
        wr(12'h014, 8'h02);
        chk("R9 masked", irq_o, 0);
        rx_rdy_i = 1'b1;
        tick();
        rd(12'h014, 8'h03, "R8 rx int from ready");
        chk("R9 rx irq", irq_o, 1);
        wr(12'h000, 8'h40);
        rd(12'h014, 8'h01, "R8 rx int follows full");
        chk("R9 rx irq off", irq_o, 0);
        rx_full_i = 1'b1;
        tick();
        rd(12'h014, 8'h03, "R8 full int");
        chk("R9 full irq", irq_o, 1);
        rx_rdy_i = 1'b0; rx_full_i = 1'b0;

        brk_evt_i = 1'b1;
        tick();
        brk_evt_i = 1'b0;
        rd(12'h014, 8'h05, "R8 break set");
        wr(12'h014, 8'h04);
        chk("R9 break irq", irq_o, 1);
        wr(12'h008, 8'h50);
        rd(12'h014, 8'h01, "R8 break cleared");
        chk("R9 break irq off", irq_o, 0);
        brk_evt_i = 1'b1;
        wr(12'h008, 8'h50);
        brk_evt_i = 1'b0;
        rd(12'h014, 8'h05, "R8 set wins over clear");

        tick();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule